// File: doc/BRIEF.md
# Ownership-based snooping cache coherence controller

This block keeps the coherence state of a direct-mapped, write-back cache that sits on a shared snooping bus. Each line carries a tag, four data words and one of four states: Invalid, Valid, Shared-Dirty or Dirty. A line in Shared-Dirty or Dirty is owned by this cache. When another cache misses on an owned line, this cache supplies the block directly over the bus. Memory is left stale and the owner keeps the duty to write the block back later.

On the processor side the block answers hits in the same cycle. When a request needs the bus, it raises a request and presents one of four commands: read miss, write miss, invalidate or write-back. A replacement of an owned line writes the victim back before the miss for the new block is issued. A completed miss installs the line, and the held request then finishes as an ordinary hit in the next cycle. On the snoop side the block looks up the address of another cache's transaction in the same cycle. It raises the supply flag with the block when it owns the line, and it downgrades or drops its own copy as the command requires. Arbitration, memory and the other caches belong to the environment.

Top module: `coh_owner_ctrl`

## Requirements
- R1: After reset every line is Invalid. A first processor read raises `bus_req` with command 1 (read miss) at the block address, and a snooped read of that block is not supplied.
- R2: A read that hits is acknowledged in the same cycle with the addressed word and without a bus request. Word w of a block occupies bits [w*DATA_W +: DATA_W]. The word address is the block address followed by a 2-bit word offset. The index is the low IDX_W bits of the block address. A read miss with grant and `bus_done` installs the block from `bus_rblock`, and the held read is acknowledged in the following cycle.
- R3: A line filled by a read miss is installed as Valid. Valid is not an owner state, so a snooped read miss (command 1) to it is not supplied.
- R4: A write that hits a Valid or Shared-Dirty line issues command 3 (invalidate). The invalidate completes in its one granted cycle without `bus_done`, and the line becomes Dirty. The write itself is acknowledged in the next cycle.
- R5: A write that hits a Dirty line is acknowledged in the same cycle with no bus request.
- R6: A write miss issues command 2 (write miss). On completion it installs the supplied block as Dirty and then merges the written word.
- R7: A snooped read miss that hits a Dirty line is supplied with the block, and the line moves to Shared-Dirty. A later snooped read miss is still supplied with unchanged data. No write-back is issued for the shared block.
- R8: A snooped write miss (command 2) that hits an owned line is supplied. A snooped write miss or invalidate (command 3) that hits any valid line leaves it Invalid, so the next processor access misses without a write-back.
- R9: A miss whose victim line is Dirty or Shared-Dirty first issues command 4 (write-back) with the victim's block address and data, then the miss. A Valid victim is dropped without a write-back.
- R10: In a cycle with `snp_valid` high the processor request is not acknowledged. The snoop has priority.
- R11: A snoop whose tag differs from the line at its index has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ack | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_ack` |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 3 | 0 none, 1 read miss, 2 write miss, 3 invalidate, 4 write-back |
| bus_addr | output | ADDR_W-2 | Block address of the transaction |
| bus_wblock | output | 4*DATA_W | Victim block for a write-back |
| bus_gnt | input | 1 | Bus granted to this cache this cycle |
| bus_done | input | 1 | Data phase of a granted transaction completes |
| bus_rblock | input | 4*DATA_W | Block delivered by the owner for a miss |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 3 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W-2 | Snooped block address |
| snp_supply | output | 1 | This cache owns the block and supplies it |
| snp_block | output | 4*DATA_W | Supplied block |

## Verification
The bench drives one block through a full ownership cycle: read miss to Valid, an invalidating write hit to Dirty, and a silent Dirty write. A snooped read then downgrades the line to Shared-Dirty, a second invalidate follows, and a snooped write miss takes the line away. Snoop supplies are checked for both the flag and the merged data, which separates a correct ownership hand-off from a stale memory copy. Replacement is tried with Shared-Dirty, Dirty and Valid victims, which shows whether the write-back decision follows ownership and not the line's last access type. Colliding snoops and unrelated-tag snoops separate the snoop-priority rule from the tag match.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_VAL = 2'd1,
    LS_SHD = 2'd2,
    LS_DRT = 2'd3
  } line_st_e;

  typedef enum logic [2:0] {
    BC_NONE   = 3'd0,
    BC_RDMISS = 3'd1,
    BC_WRMISS = 3'd2,
    BC_INVAL  = 3'd3,
    BC_WBACK  = 3'd4
  } bus_cmd_e;

  function automatic logic is_owner(line_st_e st);
    return (st == LS_SHD) || (st == LS_DRT);
  endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 11,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        cpu_idx,
  output line_st_e                cpu_state,
  output logic [TAG_W-1:0]        cpu_tag,
  output logic [WORDS*DATA_W-1:0] cpu_block,
  input  logic [IDX_W-1:0]        snp_idx,
  output line_st_e                snp_state,
  output logic [TAG_W-1:0]        snp_tag,
  output logic [WORDS*DATA_W-1:0] snp_block,
  input  logic                    snp_we,
  input  line_st_e                snp_new_state,
  input  logic                    cpu_st_we,
  input  line_st_e                cpu_new_state,
  input  logic                    fill_we,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic [WORDS*DATA_W-1:0] fill_block,
  input  logic                    word_we,
  input  logic [$clog2(WORDS)-1:0] word_sel,
  input  logic [DATA_W-1:0]       word_data
);

  localparam int LINES = 1 << IDX_W;
  localparam int OFF_W = $clog2(WORDS);

  line_st_e          st_q [LINES];
  line_st_e          st_d [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] data_q [LINES][WORDS];

  // next state: the snoop port wins over the processor port
  always_comb begin
    st_d = st_q;
    if (cpu_st_we) st_d[cpu_idx] = cpu_new_state;
    if (snp_we)    st_d[snp_idx] = snp_new_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
    end else begin
      st_q <= st_d;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel;
    assign sel = (cpu_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (fill_we && sel) tag_q[g] <= fill_tag;
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (fill_we && sel)
          data_q[g][w] <= fill_block[w*DATA_W +: DATA_W];
        else if (word_we && sel && (word_sel == OFF_W'(w)))
          data_q[g][w] <= word_data;
      end
    end
  end

  assign cpu_state = st_q[cpu_idx];
  assign cpu_tag   = tag_q[cpu_idx];
  assign snp_state = st_q[snp_idx];
  assign snp_tag   = tag_q[snp_idx];

  for (genvar w = 0; w < WORDS; w++) begin : g_rd
    assign cpu_block[w*DATA_W +: DATA_W] = data_q[cpu_idx][w];
    assign snp_block[w*DATA_W +: DATA_W] = data_q[snp_idx][w];
  end

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int TAG_W = 11
) (
  input  logic             snp_valid,
  input  logic [2:0]       snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  line_st_e         line_state,
  input  logic [TAG_W-1:0] line_tag,
  output logic             supply,
  output logic             st_we,
  output line_st_e         new_state
);

  logic match;

  always_comb begin
    match     = snp_valid && (line_state != LS_INV) && (line_tag == snp_tag);
    supply    = 1'b0;
    st_we     = 1'b0;
    new_state = line_state;
    if (match) begin
      case (snp_cmd)
        3'(BC_RDMISS): begin
          supply = is_owner(line_state);
          if (line_state == LS_DRT) begin
            st_we     = 1'b1;
            new_state = LS_SHD;
          end
        end
        3'(BC_WRMISS): begin
          supply    = is_owner(line_state);
          st_we     = 1'b1;
          new_state = LS_INV;
        end
        3'(BC_INVAL): begin
          st_we     = 1'b1;
          new_state = LS_INV;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/coh_req_ctrl.sv
module coh_req_ctrl
  import coh_pkg::*;
#(
  parameter int TAG_W = 11
) (
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [TAG_W-1:0] req_tag,
  input  line_st_e         line_state,
  input  logic [TAG_W-1:0] line_tag,
  input  logic             snp_busy,
  input  logic             bus_gnt,
  input  logic             bus_done,
  output bus_cmd_e         action,
  output logic             use_victim,
  output logic             cpu_ack,
  output logic             st_we,
  output line_st_e         new_state,
  output logic             fill_we,
  output logic             word_we
);

  logic hit;
  logic finish;

  always_comb begin
    hit        = (line_state != LS_INV) && (line_tag == req_tag);
    action     = BC_NONE;
    use_victim = 1'b0;
    if (cpu_req) begin
      if (!hit && is_owner(line_state)) begin
        action     = BC_WBACK;
        use_victim = 1'b1;
      end else if (!hit) begin
        action = cpu_we ? BC_WRMISS : BC_RDMISS;
      end else if (cpu_we && (line_state != LS_DRT)) begin
        action = BC_INVAL;
      end
    end
  end

  always_comb begin
    cpu_ack   = cpu_req && (action == BC_NONE) && !snp_busy;
    word_we   = cpu_ack && cpu_we;
    finish    = bus_gnt && bus_done;
    st_we     = 1'b0;
    fill_we   = 1'b0;
    new_state = line_state;
    case (action)
      BC_INVAL: begin
        st_we     = bus_gnt;
        new_state = LS_DRT;
      end
      BC_WBACK: begin
        st_we     = finish;
        new_state = LS_INV;
      end
      BC_RDMISS: begin
        st_we     = finish;
        fill_we   = finish;
        new_state = LS_VAL;
      end
      BC_WRMISS: begin
        st_we     = finish;
        fill_we   = finish;
        new_state = LS_DRT;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/coh_owner_ctrl.sv
module coh_owner_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_req,
  input  logic                          cpu_we,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [DATA_W-1:0]             cpu_wdata,
  output logic                          cpu_ack,
  output logic [DATA_W-1:0]             cpu_rdata,
  output logic                          bus_req,
  output logic [2:0]                    bus_cmd,
  output logic [ADDR_W-$clog2(WORDS)-1:0] bus_addr,
  output logic [WORDS*DATA_W-1:0]       bus_wblock,
  input  logic                          bus_gnt,
  input  logic                          bus_done,
  input  logic [WORDS*DATA_W-1:0]       bus_rblock,
  input  logic                          snp_valid,
  input  logic [2:0]                    snp_cmd,
  input  logic [ADDR_W-$clog2(WORDS)-1:0] snp_addr,
  output logic                          snp_supply,
  output logic [WORDS*DATA_W-1:0]       snp_block
);

  localparam int OFF_W   = $clog2(WORDS);
  localparam int BLK_W   = ADDR_W - OFF_W;
  localparam int TAG_W   = BLK_W - IDX_W;
  localparam int BLOCK_W = WORDS * DATA_W;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [OFF_W-1:0] req_off;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag;

  assign req_off = cpu_addr[OFF_W-1:0];
  assign req_idx = cpu_addr[OFF_W +: IDX_W];
  assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign s_idx   = snp_addr[IDX_W-1:0];
  assign s_tag   = snp_addr[BLK_W-1 -: TAG_W];

  line_st_e           c_state, s_state, s_new, c_new;
  logic [TAG_W-1:0]   c_tag, s_ltag;
  logic [BLOCK_W-1:0] c_block;
  logic               s_we, c_st_we, c_fill, c_word, victim;
  bus_cmd_e           act;

  coh_line_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W),
    .WORDS (WORDS)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cpu_idx      (req_idx),
    .cpu_state    (c_state),
    .cpu_tag      (c_tag),
    .cpu_block    (c_block),
    .snp_idx      (s_idx),
    .snp_state    (s_state),
    .snp_tag      (s_ltag),
    .snp_block    (snp_block),
    .snp_we       (s_we),
    .snp_new_state(s_new),
    .cpu_st_we    (c_st_we),
    .cpu_new_state(c_new),
    .fill_we      (c_fill),
    .fill_tag     (req_tag),
    .fill_block   (bus_rblock),
    .word_we      (c_word),
    .word_sel     (req_off),
    .word_data    (cpu_wdata)
  );

  coh_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_tag   (s_tag),
    .line_state(s_state),
    .line_tag  (s_ltag),
    .supply    (snp_supply),
    .st_we     (s_we),
    .new_state (s_new)
  );

  coh_req_ctrl #(.TAG_W(TAG_W)) u_req (
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .req_tag   (req_tag),
    .line_state(c_state),
    .line_tag  (c_tag),
    .snp_busy  (snp_valid),
    .bus_gnt   (bus_gnt),
    .bus_done  (bus_done),
    .action    (act),
    .use_victim(victim),
    .cpu_ack   (cpu_ack),
    .st_we     (c_st_we),
    .new_state (c_new),
    .fill_we   (c_fill),
    .word_we   (c_word)
  );

  assign cpu_rdata  = c_block[req_off*DATA_W +: DATA_W];
  assign bus_req    = (act != BC_NONE);
  assign bus_cmd    = act;
  assign bus_addr   = victim ? {c_tag, req_idx} : {req_tag, req_idx};
  assign bus_wblock = c_block;

endmodule

// File: rtl/coh_owner_chk.sv
module coh_owner_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cpu_req,
  input logic                          cpu_we,
  input logic [ADDR_W-1:0]             cpu_addr,
  input logic                          cpu_ack,
  input logic [DATA_W-1:0]             cpu_rdata,
  input logic                          bus_req,
  input logic [2:0]                    bus_cmd,
  input logic [ADDR_W-$clog2(WORDS)-1:0] bus_addr,
  input logic                          bus_gnt,
  input logic                          bus_done,
  input logic [WORDS*DATA_W-1:0]       bus_rblock,
  input logic                          snp_valid,
  input logic [2:0]                    snp_cmd,
  input logic [ADDR_W-$clog2(WORDS)-1:0] snp_addr,
  input logic                          snp_supply,
  input logic [WORDS*DATA_W-1:0]       snp_block
);

  localparam int OFF_W   = $clog2(WORDS);
  localparam int BLOCK_W = WORDS * DATA_W;

  function automatic logic [DATA_W-1:0] pick(logic [BLOCK_W-1:0] b, logic [OFF_W-1:0] o);
    return b[o*DATA_W +: DATA_W];
  endfunction

  // R2
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_gnt && bus_done && bus_cmd == 3'd1) && cpu_req && !cpu_we &&
     cpu_addr == $past(cpu_addr) && !snp_valid)
    |-> (cpu_ack && cpu_rdata == pick($past(bus_rblock), cpu_addr[OFF_W-1:0])));

  // R4
  inval_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_gnt && bus_cmd == 3'd3) && cpu_req && cpu_we &&
     cpu_addr == $past(cpu_addr) && !snp_valid)
    |-> (cpu_ack && !bus_req));

  // R7
  supply_only_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_valid && (snp_cmd == 3'd1 || snp_cmd == 3'd2)));

  // R7
  shared_owner_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(snp_supply && snp_cmd == 3'd1) && !$past(bus_gnt) && snp_valid &&
     snp_cmd == 3'd1 && snp_addr == $past(snp_addr))
    |-> (snp_supply && snp_block == $past(snp_block)));

  // R8
  snoop_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(snp_valid && (snp_cmd == 3'd2 || snp_cmd == 3'd3)) && snp_valid &&
     snp_addr == $past(snp_addr))
    |-> !snp_supply);

  // R9
  single_wback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_gnt && bus_done && bus_cmd == 3'd4) && cpu_req &&
     cpu_addr == $past(cpu_addr))
    |-> !(bus_cmd == 3'd4 && bus_addr == $past(bus_addr)));

endmodule

bind coh_owner_ctrl coh_owner_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .WORDS (WORDS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_addr  (cpu_addr),
  .cpu_ack   (cpu_ack),
  .cpu_rdata (cpu_rdata),
  .bus_req   (bus_req),
  .bus_cmd   (bus_cmd),
  .bus_addr  (bus_addr),
  .bus_gnt   (bus_gnt),
  .bus_done  (bus_done),
  .bus_rblock(bus_rblock),
  .snp_valid (snp_valid),
  .snp_cmd   (snp_cmd),
  .snp_addr  (snp_addr),
  .snp_supply(snp_supply),
  .snp_block (snp_block)
);

// File: tb/coh_owner_ctrl_tb.sv
`timescale 1ns/1ps
module coh_owner_ctrl_tb;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int BW = 14;
  localparam int KW = 128;

  logic          clk, rst_n;
  logic          cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic          cpu_ack, bus_req, bus_gnt, bus_done;
  logic [2:0]    bus_cmd, snp_cmd;
  logic [BW-1:0] bus_addr, snp_addr;
  logic [KW-1:0] bus_wblock, bus_rblock, snp_block;
  logic          snp_valid, snp_supply;

  int checks = 0;
  int errors = 0;

  logic [2:0]    lg_cmd  [4];
  logic [BW-1:0] lg_addr [4];
  logic [KW-1:0] lg_wb   [4];
  int            lg_n;
  logic          lg_ack;

  coh_owner_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wblock(bus_wblock),
    .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_rblock(bus_rblock),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_supply(snp_supply), .snp_block(snp_block)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [KW-1:0] pat(logic [BW-1:0] blk);
    logic [KW-1:0] b;
    for (int w = 0; w < 4; w++) b[w*DW +: DW] = {2'b00, blk, 8'hA5, 8'(w)};
    return b;
  endfunction

  function automatic logic [KW-1:0] put(logic [KW-1:0] b, int w, logic [DW-1:0] d);
    logic [KW-1:0] r;
    r = b;
    r[w*DW +: DW] = d;
    return r;
  endfunction

  task automatic chk(string req, string what, logic [KW-1:0] act, logic [KW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    bus_gnt = 0; bus_done = 0; bus_rblock = '0;
    snp_valid = 0; snp_cmd = '0; snp_addr = '0;
  endtask

  // processor access; the bench plays arbiter and memory, logging bus traffic
  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd);
    lg_n = 0; lg_ack = 0; rd = '0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      bus_gnt = 0; bus_done = 0;
      #1;
      if (cpu_ack) begin
        rd = cpu_rdata; lg_ack = 1;
        @(posedge clk);
        break;
      end
      if (bus_req && lg_n < 4) begin
        lg_cmd[lg_n] = bus_cmd; lg_addr[lg_n] = bus_addr; lg_wb[lg_n] = bus_wblock;
        lg_n++;
        bus_gnt = 1; bus_done = 1; bus_rblock = pat(bus_addr);
      end
      @(posedge clk);
    end
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic snoop(input logic [2:0] cmd, input logic [BW-1:0] blk,
                       input logic exp_sup, input logic [KW-1:0] exp_blk, string req);
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = blk;
    #1;
    chk(req, "snoop supply", KW'(snp_supply), KW'(exp_sup));
    if (exp_sup) chk(req, "snoop block", snp_block, exp_blk);
    chk(req, "no bus request on snoop", KW'(bus_req), '0);
    @(posedge clk);
    @(negedge clk);
    clear_inputs();
  endtask

  logic [KW-1:0] blk_a;
  logic [KW-1:0] blk_b;
  logic [KW-1:0] blk_d;
  logic [DW-1:0] rd;

  task automatic t_reset();
    @(negedge clk);
    cpu_req = 1; cpu_addr = 16'h0042;
    #1;
    chk("R1", "ack after reset", KW'(cpu_ack), '0);
    chk("R1", "bus_req", KW'(bus_req), 1);
    chk("R1", "cmd read miss", KW'(bus_cmd), 1);
    chk("R1", "block address", KW'(bus_addr), KW'(14'h010));
    @(negedge clk);
    clear_inputs();
    snoop(3'd1, 14'h010, 1'b0, '0, "R1");
  endtask

  task automatic t_read();
    cpu_op(0, 16'h0042, '0, rd);
    chk("R2", "miss transactions", KW'(lg_n), 1);
    chk("R2", "miss cmd", KW'(lg_cmd[0]), 1);
    chk("R2", "miss addr", KW'(lg_addr[0]), KW'(14'h010));
    chk("R2", "miss data", KW'(rd), KW'(pat(14'h010)[2*DW +: DW]));
    cpu_op(0, 16'h0043, '0, rd);
    chk("R2", "hit transactions", KW'(lg_n), 0);
    chk("R2", "hit ack", KW'(lg_ack), 1);
    chk("R2", "hit data", KW'(rd), KW'(pat(14'h010)[3*DW +: DW]));
  endtask

  task automatic t_valid_not_owner();
    snoop(3'd1, 14'h010, 1'b0, '0, "R3");
  endtask

  task automatic t_write_hits();
    blk_a = pat(14'h010);
    cpu_op(1, 16'h0041, 32'hDEAD0001, rd);
    blk_a = put(blk_a, 1, 32'hDEAD0001);
    chk("R4", "valid write transactions", KW'(lg_n), 1);
    chk("R4", "invalidate cmd", KW'(lg_cmd[0]), 3);
    chk("R4", "write acked", KW'(lg_ack), 1);
    cpu_op(1, 16'h0042, 32'hDEAD0002, rd);
    blk_a = put(blk_a, 2, 32'hDEAD0002);
    chk("R5", "dirty write transactions", KW'(lg_n), 0);
    chk("R5", "dirty write ack", KW'(lg_ack), 1);
  endtask

  task automatic t_share_dirty();
    snoop(3'd1, 14'h010, 1'b1, blk_a, "R7");
    snoop(3'd1, 14'h010, 1'b1, blk_a, "R7");
    cpu_op(0, 16'h0041, '0, rd);
    chk("R7", "shared read no traffic", KW'(lg_n), 0);
    chk("R7", "shared read data", KW'(rd), KW'(32'hDEAD0001));
    cpu_op(1, 16'h0040, 32'hDEAD0000, rd);
    blk_a = put(blk_a, 0, 32'hDEAD0000);
    chk("R4", "shared-dirty write transactions", KW'(lg_n), 1);
    chk("R4", "shared-dirty invalidate", KW'(lg_cmd[0]), 3);
  endtask

  task automatic t_snoop_kill();
    snoop(3'd2, 14'h010, 1'b1, blk_a, "R8");
    cpu_op(0, 16'h0040, '0, rd);
    chk("R8", "after write miss transactions", KW'(lg_n), 1);
    chk("R8", "after write miss cmd", KW'(lg_cmd[0]), 1);
    chk("R8", "refetched data", KW'(rd), KW'(pat(14'h010)[0 +: DW]));
    snoop(3'd3, 14'h010, 1'b0, '0, "R8");
    cpu_op(0, 16'h0041, '0, rd);
    chk("R8", "after invalidate cmd", KW'(lg_cmd[0]), 1);
    chk("R8", "after invalidate transactions", KW'(lg_n), 1);
  endtask

  task automatic t_write_miss();
    cpu_op(1, 16'h0085, 32'hCAFE0001, rd);
    blk_b = put(pat(14'h021), 1, 32'hCAFE0001);
    chk("R6", "write miss transactions", KW'(lg_n), 1);
    chk("R6", "write miss cmd", KW'(lg_cmd[0]), 2);
    chk("R6", "write miss addr", KW'(lg_addr[0]), KW'(14'h021));
    chk("R6", "write miss ack", KW'(lg_ack), 1);
    snoop(3'd1, 14'h021, 1'b1, blk_b, "R6");
  endtask

  task automatic t_replace();
    cpu_op(0, 16'h0104, '0, rd);
    chk("R9", "shared-dirty victim transactions", KW'(lg_n), 2);
    chk("R9", "write-back cmd", KW'(lg_cmd[0]), 4);
    chk("R9", "write-back addr", KW'(lg_addr[0]), KW'(14'h021));
    chk("R9", "write-back data", lg_wb[0], blk_b);
    chk("R9", "miss after write-back", KW'(lg_cmd[1]), 1);
    chk("R9", "new data", KW'(rd), KW'(pat(14'h041)[0 +: DW]));
    cpu_op(0, 16'h0204, '0, rd);
    chk("R9", "valid victim transactions", KW'(lg_n), 1);
    chk("R9", "valid victim cmd", KW'(lg_cmd[0]), 1);
    cpu_op(1, 16'h0206, 32'hBEEF0002, rd);
    blk_d = put(pat(14'h081), 2, 32'hBEEF0002);
    cpu_op(0, 16'h0104, '0, rd);
    chk("R9", "dirty victim transactions", KW'(lg_n), 2);
    chk("R9", "dirty write-back cmd", KW'(lg_cmd[0]), 4);
    chk("R9", "dirty write-back addr", KW'(lg_addr[0]), KW'(14'h081));
    chk("R9", "dirty write-back data", lg_wb[0], blk_d);
  endtask

  task automatic t_snoop_priority();
    @(negedge clk);
    cpu_req = 1; cpu_addr = 16'h0105;
    snp_valid = 1; snp_cmd = 3'd1; snp_addr = 14'h100;
    #1;
    chk("R10", "ack held during snoop", KW'(cpu_ack), '0);
    chk("R10", "no bus request", KW'(bus_req), '0);
    @(negedge clk);
    snp_valid = 0;
    #1;
    chk("R10", "ack after snoop", KW'(cpu_ack), 1);
    chk("R10", "data after snoop", KW'(cpu_rdata), KW'(pat(14'h041)[DW +: DW]));
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic t_other_tag();
    snoop(3'd2, 14'h0C1, 1'b0, '0, "R11");
    snoop(3'd3, 14'h0C1, 1'b0, '0, "R11");
    cpu_op(0, 16'h0104, '0, rd);
    chk("R11", "line kept", KW'(lg_n), 0);
    chk("R11", "data kept", KW'(rd), KW'(pat(14'h041)[0 +: DW]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    t_reset();
    t_read();
    t_valid_not_owner();
    t_write_hits();
    t_share_dirty();
    t_snoop_kill();
    t_write_miss();
    t_replace();
    t_snoop_priority();
    t_other_tag();
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule